// File: doc/BRIEF.md
# Video Output FIFO with Hysteresis Fill Flags

This block sits between the pixel packing stage and the image output port of a video pipeline. It stores up to 32 words of 32 bits, which is 64 pixels of 16-bit 4:2:2 data. Words leave in the order they arrived. The oldest stored word is always visible on the read data output.

The block reports how full it is through four registered flags:
- an almost-empty flag;
- an almost-full flag;
- a combined fill flag that switches with hysteresis between the two marks;
- a sticky overflow flag.

Each mark is picked from a small fixed table by a 2-bit code. Two general-purpose pins can each carry any one of the four flags, chosen by a 2-bit selector per pin. The pins let the downstream port pace its bursts.

The block runs on one clock. The asynchronous active-low reset passes through a two-stage release synchronizer.

Top module: `vfifo_hyst`

## Requirements
- R1: While reset is applied, and right after reset, `flag_aempty` is 1 and `flag_afull`, `flag_fill` and `flag_ovf` are 0.
- R2: Words are read in write order. Capacity is 32 words. While the FIFO holds data, `rd_data` shows the oldest stored word. A read with `rd_en` removes that word at the clock edge.
- R3: A write while the FIFO holds 32 words is dropped and sets `flag_ovf`. `flag_ovf` stays 1 until a cycle with `ovf_clr` high. If an overflowing write and `ovf_clr` fall in the same cycle, the flag stays set.
- R4: A read while the FIFO is empty is ignored. An accepted read together with an accepted write leaves the fill level unchanged. A write together with a read while full is still dropped, so only the read takes effect.
- R5: `flag_afull` is 1 while the fill level is at least the high mark. `afull_code` selects the high mark: 0 gives 16, 1 gives 24, 2 gives 28, 3 gives 32.
- R6: `flag_aempty` is 1 while the fill level is at most the low mark. `aempty_code` selects the low mark: 0 gives 16, 1 gives 8, 2 gives 4, 3 gives 0.
- R7: `flag_fill` becomes 1 when the fill level reaches the high mark. It becomes 0 only when the fill level is at or under the low mark. In between it holds its value. If both conditions hold, setting wins.
- R8: All flags are registered. After the clock edge that performs an access, the flags reflect the new fill level. A change of a threshold code takes effect at the following clock edge.
- R9: `pin0` and `pin1` each show the flag picked by their selector: 0 almost empty, 1 almost full, 2 combined fill, 3 overflow.
- R10: After `rst_n` rises, the first two clock edges still hold the block in reset, so accesses during them have no effect. The third edge is the first active one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write request |
| wr_data | input | 32 | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | 32 | Oldest stored word |
| afull_code | input | 2 | High mark selection code |
| aempty_code | input | 2 | Low mark selection code |
| pin0_sel | input | 2 | Flag routed to pin0 |
| pin1_sel | input | 2 | Flag routed to pin1 |
| ovf_clr | input | 1 | Clears the overflow flag |
| flag_aempty | output | 1 | Almost-empty flag |
| flag_afull | output | 1 | Almost-full flag |
| flag_fill | output | 1 | Combined fill flag with hysteresis |
| flag_ovf | output | 1 | Sticky overflow flag |
| pin0 | output | 1 | General-purpose flag pin 0 |
| pin1 | output | 1 | General-purpose flag pin 1 |

## Verification
The hardest states to reach from the ports are the hysteresis band of the combined flag and the overflow corner where a dropped write meets a clear in the same cycle. Each needs the FIFO driven all the way to 32 words under a given pair of threshold codes. The bench sweeps all sixteen code pairs. For each pair it fills past capacity with the last write colliding with `ovf_clr`, then drains past empty. Along the way it compares every flag and both pins against an arithmetic model on every cycle. A mid-level phase of paired reads and writes and a reset-release window with writes pending cover the remaining corners.

// File: rtl/vfifo_pkg.sv
package vfifo_pkg;

  typedef enum logic [1:0] {
    SEL_AEMPTY = 2'd0,
    SEL_AFULL  = 2'd1,
    SEL_FILL   = 2'd2,
    SEL_OVF    = 2'd3
  } flag_sel_e;

  // High mark: half, three quarters, seven eighths, or all of the depth
  function automatic int unsigned hi_mark(input logic [1:0] code, input int unsigned depth);
    case (code)
      2'd0:    return depth / 2;
      2'd1:    return depth - depth / 4;
      2'd2:    return depth - depth / 8;
      default: return depth;
    endcase
  endfunction

  // Low mark: half, quarter, eighth of the depth, or zero
  function automatic int unsigned lo_mark(input logic [1:0] code, input int unsigned depth);
    case (code)
      2'd0:    return depth / 2;
      2'd1:    return depth / 4;
      2'd2:    return depth / 8;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/vfifo_store.sv
module vfifo_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_acc,
  input  logic              rd_acc,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wptr_q, wptr_n;
  logic [AW-1:0]     rptr_q, rptr_n;

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    if (wr_acc) wptr_n = wptr_q + AW'(1);
    if (rd_acc) rptr_n = rptr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
    end
  end

  // Storage array without reset, written only on accepted writes
  always_ff @(posedge clk) begin
    if (wr_acc) mem_q[wptr_q] <= wr_data;
  end

  assign rd_data = mem_q[rptr_q];

endmodule

// File: rtl/vfifo_level.sv
module vfifo_level
  import vfifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          ovf_clr,
  input  logic [1:0]    afull_code,
  input  logic [1:0]    aempty_code,
  output logic          wr_acc,
  output logic          rd_acc,
  output logic [CW-1:0] cnt,
  output logic          aempty,
  output logic          afull,
  output logic          fill,
  output logic          ovf
);
  logic [CW-1:0] cnt_q, cnt_n;
  logic [CW-1:0] hi_thr, lo_thr;
  logic          is_full, is_empty;
  logic          aempty_q, aempty_n;
  logic          afull_q, afull_n;
  logic          fill_q, fill_n;
  logic          ovf_q, ovf_n;

  assign hi_thr   = CW'(hi_mark(afull_code, DEPTH));
  assign lo_thr   = CW'(lo_mark(aempty_code, DEPTH));
  assign is_full  = (cnt_q == CW'(DEPTH));
  assign is_empty = (cnt_q == '0);
  assign wr_acc   = wr_en & ~is_full;
  assign rd_acc   = rd_en & ~is_empty;

  always_comb begin
    cnt_n = cnt_q;
    case ({wr_acc, rd_acc})
      2'b10:   cnt_n = cnt_q + CW'(1);
      2'b01:   cnt_n = cnt_q - CW'(1);
      default: cnt_n = cnt_q;
    endcase
    afull_n  = (cnt_n >= hi_thr);
    aempty_n = (cnt_n <= lo_thr);
    if (afull_n)       fill_n = 1'b1;
    else if (aempty_n) fill_n = 1'b0;
    else               fill_n = fill_q;
    ovf_n = (wr_en & is_full) | (ovf_q & ~ovf_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      aempty_q <= 1'b1;
      afull_q  <= 1'b0;
      fill_q   <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      aempty_q <= aempty_n;
      afull_q  <= afull_n;
      fill_q   <= fill_n;
      ovf_q    <= ovf_n;
    end
  end

  assign cnt    = cnt_q;
  assign aempty = aempty_q;
  assign afull  = afull_q;
  assign fill   = fill_q;
  assign ovf    = ovf_q;

endmodule

// File: rtl/vfifo_route.sv
module vfifo_route
  import vfifo_pkg::*;
#(
  parameter int NPINS = 2
) (
  input  logic [3:0]         flags,   // {ovf, fill, afull, aempty}
  input  logic [2*NPINS-1:0] sel,
  output logic [NPINS-1:0]   pins
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    flag_sel_e choice;
    assign choice = flag_sel_e'(sel[2*p +: 2]);
    always_comb begin
      case (choice)
        SEL_AEMPTY: pins[p] = flags[0];
        SEL_AFULL:  pins[p] = flags[1];
        SEL_FILL:   pins[p] = flags[2];
        default:    pins[p] = flags[3];
      endcase
    end
  end

endmodule

// File: rtl/vfifo_hyst.sv
module vfifo_hyst #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [1:0]        afull_code,
  input  logic [1:0]        aempty_code,
  input  logic [1:0]        pin0_sel,
  input  logic [1:0]        pin1_sel,
  input  logic              ovf_clr,
  output logic              flag_aempty,
  output logic              flag_afull,
  output logic              flag_fill,
  output logic              flag_ovf,
  output logic              pin0,
  output logic              pin1
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [1:0]    rst_sync_q;
  logic          rst_core_n;
  logic          wr_acc, rd_acc;
  logic [CW-1:0] fill_cnt;
  logic [1:0]    pin_bus;

  // Assert asynchronously, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  vfifo_level #(.DEPTH(DEPTH)) u_level (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .ovf_clr     (ovf_clr),
    .afull_code  (afull_code),
    .aempty_code (aempty_code),
    .wr_acc      (wr_acc),
    .rd_acc      (rd_acc),
    .cnt         (fill_cnt),
    .aempty      (flag_aempty),
    .afull       (flag_afull),
    .fill        (flag_fill),
    .ovf         (flag_ovf)
  );

  vfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .wr_acc  (wr_acc),
    .rd_acc  (rd_acc),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  vfifo_route #(.NPINS(2)) u_route (
    .flags ({flag_ovf, flag_fill, flag_afull, flag_aempty}),
    .sel   ({pin1_sel, pin0_sel}),
    .pins  (pin_bus)
  );

  assign pin0 = pin_bus[0];
  assign pin1 = pin_bus[1];

endmodule

// File: rtl/vfifo_hyst_chk.sv
module vfifo_hyst_chk #(
  parameter int DEPTH = 32,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_core_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          ovf_clr,
  input logic [CW-1:0] fill_cnt,
  input logic          flag_aempty,
  input logic          flag_afull,
  input logic          flag_fill,
  input logic          flag_ovf
);
  // R2: level never exceeds capacity
  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    fill_cnt <= CW'(DEPTH));

  // R3: overflow is sticky without a clear
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (flag_ovf && !ovf_clr) |=> flag_ovf);

  // R3: write at capacity raises overflow and leaves the level alone
  p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && !rd_en && fill_cnt == CW'(DEPTH)) |=> (flag_ovf && fill_cnt == CW'(DEPTH)));

  // R4: read on empty without a write keeps the level at zero
  p_rd_empty_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_en && !wr_en && fill_cnt == '0) |=> fill_cnt == '0);

  // R4: paired accepted accesses keep the level
  p_pair_level_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && rd_en && fill_cnt != '0 && fill_cnt != CW'(DEPTH)) |=> $stable(fill_cnt));

  // R7: combined flag rises only together with almost full
  p_fill_rise_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(flag_fill) |-> flag_afull);

  // R7: combined flag falls only together with almost empty
  p_fill_fall_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(flag_fill) |-> flag_aempty);

endmodule

bind vfifo_hyst vfifo_hyst_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .ovf_clr     (ovf_clr),
  .fill_cnt    (fill_cnt),
  .flag_aempty (flag_aempty),
  .flag_afull  (flag_afull),
  .flag_fill   (flag_fill),
  .flag_ovf    (flag_ovf)
);

// File: tb/vfifo_hyst_bench.sv
module vfifo_hyst_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [1:0]  afull_code = '0;
  logic [1:0]  aempty_code = '0;
  logic [1:0]  pin0_sel = '0;
  logic [1:0]  pin1_sel = '0;
  logic        ovf_clr = 1'b0;
  logic        flag_aempty, flag_afull, flag_fill, flag_ovf, pin0, pin1;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // model state
  int          m_cnt = 0;
  int          m_rp = 0;
  int          m_wp = 0;
  logic [31:0] m_q [32];
  bit          m_ae = 1, m_af = 0, m_fill = 0, m_ovf = 0;
  int          seq = 0;

  always #10 clk = ~clk;  // 50 MHz

  vfifo_hyst u_vfifo_hyst (
    .clk, .rst_n, .wr_en, .wr_data, .rd_en, .rd_data,
    .afull_code, .aempty_code, .pin0_sel, .pin1_sel, .ovf_clr,
    .flag_aempty, .flag_afull, .flag_fill, .flag_ovf, .pin0, .pin1
  );

  function automatic int hi_exp(input logic [1:0] c);
    return (c == 2'd3) ? 32 : 32 - (32 >> (c + 1));
  endfunction

  function automatic int lo_exp(input logic [1:0] c);
    return (c == 2'd3) ? 0 : (16 >> c);
  endfunction

  function automatic bit pin_exp(input logic [1:0] s);
    case (s)
      2'd0:    return m_ae;
      2'd1:    return m_af;
      2'd2:    return m_fill;
      default: return m_ovf;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_flags();
    chk("R6 aempty", 32'(flag_aempty), 32'(m_ae));
    chk("R5 afull", 32'(flag_afull), 32'(m_af));
    chk("R7 fill", 32'(flag_fill), 32'(m_fill));
    chk("R3 ovf", 32'(flag_ovf), 32'(m_ovf));
    chk("R9 pin0", 32'(pin0), 32'(pin_exp(pin0_sel)));
    chk("R9 pin1", 32'(pin1), 32'(pin_exp(pin1_sel)));
  endtask

  // One cycle: drive at negedge, update model at posedge, check at next negedge (R8)
  task automatic cyc(input bit w, input bit r, input bit c);
    bit wa, ra;
    logic [31:0] d;
    seq++;
    d = 32'h5A00_0000 + 32'(seq) * 32'h0001_0103;
    wr_en = w; rd_en = r; ovf_clr = c; wr_data = d;
    if (r && m_cnt > 0) chk("R2 rd_data", rd_data, m_q[m_rp]);
    @(posedge clk);
    wa = w && (m_cnt < 32);
    ra = r && (m_cnt > 0);
    if (w && m_cnt == 32) m_ovf = 1;
    else if (c) m_ovf = 0;
    if (ra) m_rp = (m_rp + 1) % 32;
    if (wa) begin m_q[m_wp] = d; m_wp = (m_wp + 1) % 32; end
    m_cnt = m_cnt + (wa ? 1 : 0) - (ra ? 1 : 0);
    m_af = (m_cnt >= hi_exp(afull_code));
    m_ae = (m_cnt <= lo_exp(aempty_code));
    if (m_af) m_fill = 1;
    else if (m_ae) m_fill = 0;
    @(negedge clk);
    chk_flags();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: flags during reset
    chk("R1 aempty in reset", 32'(flag_aempty), 32'd1);
    chk("R1 afull in reset", 32'(flag_afull), 32'd0);
    chk("R1 fill in reset", 32'(flag_fill), 32'd0);
    chk("R1 ovf in reset", 32'(flag_ovf), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_flags();

    for (int cfg = 0; cfg < 16; cfg++) begin
      afull_code  = 2'(cfg >> 2);
      aempty_code = 2'(cfg);
      pin0_sel    = 2'(cfg);
      pin1_sel    = 2'(cfg + 1);
      cyc(0, 0, 0);  // R8: new codes take effect
      for (int i = 0; i < 33; i++) cyc(1, 0, 0);   // fill, one overflow
      cyc(1, 0, 1);                                // R3: set wins over clear
      cyc(1, 1, 0);                                // R4: read+write at full
      cyc(0, 0, 1);                                // R3: clear
      for (int i = 0; i < 12; i++) cyc(0, 1, 0);
      for (int i = 0; i < 4; i++) cyc(1, 1, 0);    // R4: paired accesses
      for (int i = 0; i < 22; i++) cyc(0, 1, 0);   // drain past empty
      cyc(1, 1, 0);                                // R4: empty, only write takes
      cyc(0, 1, 0);
    end

    // R10: reset during activity, then two dead edges after release
    for (int i = 0; i < 5; i++) cyc(1, 0, 0);
    rst_n = 1'b0;
    #1;
    chk("R1 aempty async reset", 32'(flag_aempty), 32'd1);
    @(negedge clk);
    m_cnt = 0; m_rp = 0; m_wp = 0; m_ae = 1; m_af = 0; m_fill = 0; m_ovf = 0;
    afull_code = 2'd0; aempty_code = 2'd3; pin0_sel = 2'd0; pin1_sel = 2'd1;
    rst_n = 1'b1;
    wr_en = 1'b1; wr_data = 32'hDEAD_0001;
    @(negedge clk);
    wr_data = 32'hDEAD_0002;
    @(negedge clk);
    chk("R10 still empty", 32'(flag_aempty), 32'd1);
    cyc(1, 0, 0);                                 // first effective write
    chk("R10 aempty after first write", 32'(flag_aempty), 32'd0);
    cyc(0, 1, 0);                                 // R2 read must see only that word
    chk("R10 empty again", 32'(flag_aempty), 32'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule